// File: doc/BRIEF.md
# Intersection Light Sequencer with Interval Timer

This block runs the lamps at a crossing of a busy main road and a quiet side road. The main road shows green by default. A vehicle detector on the side road raises an input that can change at any time. That input is first captured by a clocked register. The main road then gives way only after its green has lasted a minimum long interval and a vehicle is waiting. Each amber phase lasts a short interval. The side road keeps green until the long interval runs out or no vehicle is waiting any more. After that, control returns to the main road through the side-road amber.

The design has four parts. A sensor register turns the asynchronous detector level into a clocked one. A restartable up-counter flags a short and a long threshold and holds each flag once it is reached. A four-state controller issues a one-cycle restart to the counter on each phase change. A decoder drives one lamp of each road straight from the current state. Both thresholds are parameters, and the short one must be smaller than the long one.

Top module: `tlc_top`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the main road shows green and the side road shows red, with the interval counter at zero. With a vehicle present from reset onward, main green lasts exactly LONG_CNT+1 sampled cycles, counting the cycle in which reset is released.
- R2: The lamps depend only on the state, and each road lights exactly one lamp. The four states are: main green {main green, side red}; main amber {main yellow, side red}; side green {main red, side green}; side amber {main red, side yellow}. The internal state codes are main green 00, side green 01, main amber 10 and side amber 11.
- R3: Main green changes to main amber only when the long threshold has been reached and the registered vehicle flag is high. A vehicle that comes and goes before the long threshold has no effect.
- R4: Main amber lasts SHORT_CNT+1 cycles and then changes to side green.
- R5: While a vehicle stays present, side green lasts LONG_CNT+1 cycles and then changes to side amber.
- R6: Side green changes to side amber when the registered vehicle flag is low. After the detector drops, side green is still shown for one more sampled cycle, and amber follows on the second.
- R7: Side amber lasts SHORT_CNT+1 cycles and then changes to main green. On this new entry the counter has been restarted, so main green again lasts LONG_CNT+1 cycles if a vehicle is waiting.
- R8: The detector passes through exactly one register. A vehicle that appears while the long threshold is already reached changes main green to amber on the second clock edge after it appears.
- R9: Each phase change restarts the counter at zero. Once a threshold is reached, its flag stays set until the next restart, so main green with no vehicle holds for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_in | input | 1 | Side-road vehicle detector, asynchronous |
| hw_red | output | 1 | Main road red lamp |
| hw_yel | output | 1 | Main road yellow lamp |
| hw_grn | output | 1 | Main road green lamp |
| farm_red | output | 1 | Side road red lamp |
| farm_yel | output | 1 | Side road yellow lamp |
| farm_grn | output | 1 | Side road green lamp |

## Verification
The synchronizer property assumes that `car_in` is stable around each rising edge, so that the registered flag equals the value seen at the previous edge. The bench keeps to this by changing the detector and reset only just after a falling edge. The properties also assume that SHORT_CNT is less than LONG_CNT, and that reset is released between edges. All phase checks use the default thresholds of 4 and 12, so a single bench run covers both the short and the long windows.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    // Light phase; encoding is fixed because decoders and checks rely on it
    typedef enum logic [1:0] {
        PH_HWY_GO   = 2'b00,
        PH_FARM_GO  = 2'b01,
        PH_HWY_WARN = 2'b10,
        PH_FARM_WARN = 2'b11
    } phase_e;

    typedef struct packed {
        logic red;
        logic yel;
        logic grn;
    } lamp_t;

    typedef struct packed {
        phase_e phase;
    } ctrl_state_t;

endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tlc_timer.sv
module tlc_timer #(
    parameter int SHORT_CNT = 4,
    parameter int LONG_CNT  = 12,
    localparam int CW = $clog2(LONG_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic          ts,
    output logic          tl,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CNT);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CNT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)              cnt_d = '0;
        else if (cnt_q != LONG_V) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ts    = (cnt_q >= SHORT_V);
    assign tl    = (cnt_q >= LONG_V);
    assign count = cnt_q;
endmodule

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car,
    input  logic   ts,
    input  logic   tl,
    output phase_e phase,
    output logic   restart
);
    ctrl_state_t st_d, st_q;
    logic        go;

    always_comb begin
        st_d = st_q;
        go   = 1'b0;
        unique case (st_q.phase)
            PH_HWY_GO: begin
                go = tl && car;
                if (go) st_d.phase = PH_HWY_WARN;
            end
            PH_HWY_WARN: begin
                go = ts;
                if (go) st_d.phase = PH_FARM_GO;
            end
            PH_FARM_GO: begin
                go = tl || !car;
                if (go) st_d.phase = PH_FARM_WARN;
            end
            PH_FARM_WARN: begin
                go = ts;
                if (go) st_d.phase = PH_HWY_GO;
            end
            default: st_d.phase = PH_HWY_GO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.phase <= PH_HWY_GO;
        else        st_q       <= st_d;
    end

    assign phase   = st_q.phase;
    assign restart = go;
endmodule

// File: rtl/tlc_lamp_dec.sv
module tlc_lamp_dec
    import tlc_pkg::*;
(
    input  phase_e phase,
    output lamp_t  hwy,
    output lamp_t  farm
);
    // phase[0] selects which road is active, phase[1] selects amber
    always_comb begin
        hwy  = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
        farm = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
        if (!phase[0]) begin
            hwy.red = 1'b0;
            hwy.yel = phase[1];
            hwy.grn = !phase[1];
        end else begin
            farm.red = 1'b0;
            farm.yel = phase[1];
            farm.grn = !phase[1];
        end
    end
endmodule

// File: rtl/tlc_top.sv
module tlc_top #(
    parameter int SHORT_CNT   = 4,
    parameter int LONG_CNT    = 12,
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic car_in,
    output logic hw_red,
    output logic hw_yel,
    output logic hw_grn,
    output logic farm_red,
    output logic farm_yel,
    output logic farm_grn
);
    import tlc_pkg::*;
    localparam int CW = $clog2(LONG_CNT + 1);

    logic          car_s;
    logic          ts, tl, restart;
    logic [CW-1:0] count;
    phase_e        phase;
    lamp_t         hwy_l, farm_l;

    tlc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(car_in), .dout(car_s)
    );

    tlc_timer #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .ts(ts), .tl(tl), .count(count)
    );

    tlc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .car(car_s), .ts(ts), .tl(tl),
        .phase(phase), .restart(restart)
    );

    tlc_lamp_dec u_dec (.phase(phase), .hwy(hwy_l), .farm(farm_l));

    assign hw_red   = hwy_l.red;
    assign hw_yel   = hwy_l.yel;
    assign hw_grn   = hwy_l.grn;
    assign farm_red = farm_l.red;
    assign farm_yel = farm_l.yel;
    assign farm_grn = farm_l.grn;
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          car_in,
    input logic          car_s,
    input logic [1:0]    phase,
    input logic          restart,
    input logic          ts,
    input logic          tl,
    input logic [CW-1:0] count,
    input logic [2:0]    hwy,
    input logic [2:0]    farm
);
    // R2: one lamp per road
    p_one_lamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(hwy) == 1) && ($countones(farm) == 1));

    // R3: main green held unless long threshold and vehicle
    p_hwy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && !(tl && car_s)) |=> phase == 2'b00);

    // R4
    p_hwy_warn_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && ts) |=> phase == 2'b01);

    // R6
    p_farm_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && (tl || !car_s)) |=> phase == 2'b11);

    // R7
    p_farm_warn_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && ts) |=> phase == 2'b00);

    // R8: one register from detector to controller
    p_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> car_s == $past(car_in));

    // R9: restart zeroes the counter; flags hold until restart
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> count == '0);
    p_ts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && !restart) |=> ts);
    p_tl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tl && !restart) |=> tl);
endmodule

bind tlc_top tlc_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .car_in(car_in), .car_s(car_s),
    .phase(phase), .restart(restart), .ts(ts), .tl(tl), .count(count),
    .hwy({hw_red, hw_yel, hw_grn}), .farm({farm_red, farm_yel, farm_grn})
);

// File: tb/sim_tlc_top.sv
module sim_tlc_top;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_CNT  = 4;
    localparam int LONG_CNT   = 12;

    // {hw_red,hw_yel,hw_grn,farm_red,farm_yel,farm_grn}
    localparam logic [5:0] L_HG = 6'b001_100;
    localparam logic [5:0] L_HY = 6'b010_100;
    localparam logic [5:0] L_FG = 6'b100_001;
    localparam logic [5:0] L_FY = 6'b100_010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car_in = 1'b0;
    logic hw_red, hw_yel, hw_grn, farm_red, farm_yel, farm_grn;
    int   n_run = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlc_top #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) u0 (
        .clk(clk), .rst_n(rst_n), .car_in(car_in),
        .hw_red(hw_red), .hw_yel(hw_yel), .hw_grn(hw_grn),
        .farm_red(farm_red), .farm_yel(farm_yel), .farm_grn(farm_grn)
    );

    function automatic logic [5:0] lamps();
        return {hw_red, hw_yel, hw_grn, farm_red, farm_yel, farm_grn};
    endfunction

    task automatic chk_lamps(input string req, input logic [5:0] exp);
        n_run++;
        if (lamps() !== exp) begin
            n_fail++;
            $display("FAIL %s lamps actual %b expected %b", req, lamps(), exp);
        end
    endtask

    task automatic chk_len(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s phase length actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts consecutive falling-edge samples showing pat, from now
    task automatic run_len(input logic [5:0] pat, output int n);
        n = 0;
        while (lamps() == pat && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        car_in = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        chk_lamps("R1 during reset", L_HG);
        chk_lamps("R2 main green decode", L_HG);
        rst_n = 1'b1;
        @(negedge clk);
        chk_lamps("R1 after release", L_HG);
    endtask

    task automatic t_short_car;
        int ok = 1;
        car_in = 1'b1;
        repeat (2) @(negedge clk);
        car_in = 1'b0;
        repeat (LONG_CNT + 10) begin
            @(negedge clk);
            if (lamps() != L_HG) ok = 0;
        end
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R3 early vehicle left main green actual %b expected %b", lamps(), L_HG);
        end
    endtask

    task automatic t_idle;
        int ok = 1;
        repeat (3 * LONG_CNT) begin
            @(negedge clk);
            if (lamps() != L_HG) ok = 0;
        end
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R9 main green not held actual %b expected %b", lamps(), L_HG);
        end
    endtask

    task automatic t_full_cycle;
        int n;
        car_in = 1'b1;
        @(negedge clk);
        chk_lamps("R8 one register latency", L_HG);
        @(negedge clk);
        chk_lamps("R8 change on second edge", L_HY);
        chk_lamps("R2 main amber decode", L_HY);
        run_len(L_HY, n);
        chk_len("R4 main amber", n, SHORT_CNT + 1);
        chk_lamps("R2 side green decode", L_FG);
        run_len(L_FG, n);
        chk_len("R5 side green with vehicle", n, LONG_CNT + 1);
        chk_lamps("R2 side amber decode", L_FY);
        run_len(L_FY, n);
        chk_len("R7 side amber", n, SHORT_CNT + 1);
        chk_lamps("R7 back to main green", L_HG);
        run_len(L_HG, n);
        chk_len("R7 main green after restart", n, LONG_CNT + 1);
        chk_lamps("R3 main green to amber", L_HY);
    endtask

    task automatic t_car_leaves;
        int n;
        run_len(L_HY, n);
        chk_lamps("R6 entered side green", L_FG);
        repeat (3) @(negedge clk);
        car_in = 1'b0;
        @(negedge clk);
        chk_lamps("R6 still green one cycle", L_FG);
        @(negedge clk);
        chk_lamps("R6 amber on second cycle", L_FY);
        run_len(L_FY, n);
        chk_len("R7 side amber after early exit", n, SHORT_CNT + 1);
        chk_lamps("R7 main green again", L_HG);
    endtask

    task automatic t_reset_mid;
        int n;
        car_in = 1'b1;
        repeat (2) @(negedge clk);
        chk_lamps("R3 vehicle after long wait", L_HY);
        rst_n = 1'b0;
        #1;
        chk_lamps("R1 async reset from amber", L_HG);
        @(negedge clk);
        rst_n = 1'b1;
        run_len(L_HG, n);
        chk_len("R1 counter cleared by reset", n, LONG_CNT + 1);
        car_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_short_car();
        t_idle();
        t_full_cycle();
        t_car_leaves();
        t_idle();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule